// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects a simple request/acknowledge host port to an external asynchronous static RAM organised as 1M words of 16 bits. The RAM has two chip enables of opposite polarity, an active-low write strobe, an active-low output enable and one active-low enable per byte lane. The host presents a word address, write data, a per-byte select mask and a read/write flag. The controller then runs the RAM's control pins through a fixed sequence of clock-counted phases and reports completion with a one-cycle done pulse. For a read, the captured data comes with that pulse.

Every phase length is an integer cycle-count parameter. The designer picks each count so that the RAM's minimum times in nanoseconds are covered at the chosen clock period. At 200 MHz these minimums are: a 55 ns read cycle, a 55 ns write cycle, a 40 ns write pulse, 25 ns of data setup before the strobe rises, and up to 20 ns for the RAM to release the bus after output enable rises. The data bus is split into an output value, an input value and an output-enable so that the pad ring can build the tri-state buffer.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and after reset, with no operation in progress, the RAM is deselected (sram_ce1_n=1, sram_ce2=0), sram_we_n=1, sram_oe_n=1, both bits of sram_be_n are 1, sram_dq_oe=0 and done=0.
- R2: ack equals req in any cycle where the controller is idle and is 0 otherwise. A request is accepted at the clock edge that ends a cycle with ack high.
- R3: A read holds sram_ce1_n=0, sram_ce2=1, sram_oe_n=0, sram_we_n=1 and sram_dq_oe=0 for READ_CYCLES cycles, starting the cycle after acceptance.
- R4: A write holds sram_ce1_n=0, sram_ce2=1, sram_oe_n=1 and sram_dq_oe=1 throughout. It runs WSETUP_CYCLES cycles with sram_we_n=1, then WE_LOW_CYCLES cycles with sram_we_n=0, then WHOLD_CYCLES cycles with sram_we_n=1.
- R5: A write accepted when the previous operation was a read is preceded by TURN_CYCLES cycles with all RAM pins at their idle levels and sram_dq_oe=0.
- R6: sram_dq_oe is never 1 in a cycle where sram_oe_n is 0, and the controller never drives the bus while the RAM may still be driving it.
- R7: done is high for exactly one cycle, the cycle after an operation's last phase cycle. For a read, rdata in that cycle holds the bus value sampled in the last read cycle.
- R8: req_be bit 0 selects data bits 7:0 and bit 1 selects bits 15:8. sram_be_n bit i is 0 only for a selected lane during an operation. Unselected lanes of rdata read as zero. With req_be=0 no byte of the RAM changes.
- R9: sram_addr and, while sram_dq_oe=1, sram_dq_o hold the address and write data that were latched at acceptance, for the whole operation, whatever the host inputs do afterwards.
- R10: The default cycle counts at a 5 ns clock cover the minimum read cycle, write cycle, write pulse, data setup and bus release times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Host request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (20) | Word address |
| req_wdata | input | DW (16) | Write data |
| req_be | input | DW/8 (2) | Byte-lane select, bit 0 = bits 7:0 |
| ack | output | 1 | Request accepted at the next edge |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW (16) | Read data, valid with done |
| sram_addr | output | AW (20) | RAM address |
| sram_ce1_n | output | 1 | RAM enable, active low |
| sram_ce2 | output | 1 | RAM enable, active high |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_be_n | output | DW/8 (2) | RAM byte-lane enables, active low, bit 0 = lower lane |
| sram_dq_o | output | DW (16) | Data driven toward the RAM |
| sram_dq_i | input | DW (16) | Data from the bus |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |

## Verification
The bench exercises single-lane writes followed by reads of the other lane, so a swapped lane mapping would corrupt a byte or return the wrong one. It issues a write right after a read with a model that keeps driving the bus for 20 ns. A design that skipped the turnaround would show a bus fight. Requests are issued back to back, and the host fields are scrambled after each acceptance. A design that failed to latch the request would strobe the wrong address or data. A zero byte mask checks that no lane is enabled and no byte changes. A full-lane read after a masked write exposes unselected lanes that were not zeroed.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_READ,
    PH_WSETUP,
    PH_WLOW,
    PH_WHOLD
  } phase_e;

  // Pin levels for one phase; lanes_on lets the latched byte mask through.
  typedef struct packed {
    logic ce1_n;
    logic ce2;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic lanes_on;
  } ctl_t;

  function automatic ctl_t ctl_for(input phase_e ph);
    ctl_t c;
    c = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, lanes_on: 1'b0};
    case (ph)
      PH_READ: begin
        c.ce1_n = 1'b0; c.ce2 = 1'b1; c.oe_n = 1'b0; c.lanes_on = 1'b1;
      end
      PH_WSETUP, PH_WHOLD: begin
        c.ce1_n = 1'b0; c.ce2 = 1'b1; c.dq_oe = 1'b1; c.lanes_on = 1'b1;
      end
      PH_WLOW: begin
        c.ce1_n = 1'b0; c.ce2 = 1'b1; c.dq_oe = 1'b1; c.lanes_on = 1'b1;
        c.we_n = 1'b0;
      end
      default: ;
    endcase
    return c;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold a down-count starting at (n-1); at least one.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int READ_CYCLES   = 11,
  parameter int WSETUP_CYCLES = 1,
  parameter int WE_LOW_CYCLES = 8,
  parameter int WHOLD_CYCLES  = 2,
  parameter int TURN_CYCLES   = 4,
  parameter int CW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic          expire,
  output phase_e        phase,
  output logic          accept,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          rd_end,
  output logic          op_end
);

  phase_e nxt;
  logic   last_rd;

  always_comb begin
    nxt      = phase;
    accept   = 1'b0;
    load     = 1'b0;
    load_val = '0;
    rd_end   = 1'b0;
    op_end   = 1'b0;
    case (phase)
      PH_IDLE: if (req) begin
        accept = 1'b1;
        load   = 1'b1;
        if (!req_we) begin
          nxt = PH_READ;   load_val = CW'(READ_CYCLES - 1);
        end else if (last_rd && (TURN_CYCLES > 0)) begin
          nxt = PH_TURN;   load_val = CW'(TURN_CYCLES - 1);
        end else begin
          nxt = PH_WSETUP; load_val = CW'(WSETUP_CYCLES - 1);
        end
      end
      PH_TURN: if (expire) begin
        nxt = PH_WSETUP; load = 1'b1; load_val = CW'(WSETUP_CYCLES - 1);
      end
      PH_WSETUP: if (expire) begin
        nxt = PH_WLOW;   load = 1'b1; load_val = CW'(WE_LOW_CYCLES - 1);
      end
      PH_WLOW: if (expire) begin
        nxt = PH_WHOLD;  load = 1'b1; load_val = CW'(WHOLD_CYCLES - 1);
      end
      PH_WHOLD: if (expire) begin
        nxt = PH_IDLE;   op_end = 1'b1;
      end
      PH_READ: if (expire) begin
        nxt = PH_IDLE;   op_end = 1'b1; rd_end = 1'b1;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      last_rd <= 1'b0;
    end else begin
      phase <= nxt;
      if (rd_end)                 last_rd <= 1'b1;
      else if (phase == PH_WSETUP) last_rd <= 1'b0;
    end
  end

endmodule

// File: rtl/sram_seq_data.sv
`timescale 1ns/1ps
module sram_seq_data #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          rd_end,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [NB-1:0] in_be,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [NB-1:0] be_q,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      be_q    <= in_be;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata[i*8 +: 8] <= '0;
      else if (rd_end) rdata[i*8 +: 8] <= be_q[i] ? bus_in[i*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int READ_CYCLES   = 11,
  parameter int WSETUP_CYCLES = 1,
  parameter int WE_LOW_CYCLES = 8,
  parameter int WHOLD_CYCLES  = 2,
  parameter int TURN_CYCLES   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic            ack,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [AW-1:0]   sram_addr,
  output logic            sram_ce1_n,
  output logic            sram_ce2,
  output logic            sram_we_n,
  output logic            sram_oe_n,
  output logic [DW/8-1:0] sram_be_n,
  output logic [DW-1:0]   sram_dq_o,
  input  logic [DW-1:0]   sram_dq_i,
  output logic            sram_dq_oe
);

  localparam int NB   = DW / 8;
  localparam int MAXC = max_of(max_of(READ_CYCLES, WE_LOW_CYCLES),
                               max_of(max_of(WSETUP_CYCLES, WHOLD_CYCLES), TURN_CYCLES));
  localparam int CW   = cnt_bits(MAXC);

  phase_e        phase;
  ctl_t          ctl;
  logic          accept, load, expire, rd_end, op_end;
  logic [CW-1:0] load_val;
  logic [NB-1:0] be_q;
  logic          ctl_idle;

  sram_seq_fsm #(
    .READ_CYCLES  (READ_CYCLES),
    .WSETUP_CYCLES(WSETUP_CYCLES),
    .WE_LOW_CYCLES(WE_LOW_CYCLES),
    .WHOLD_CYCLES (WHOLD_CYCLES),
    .TURN_CYCLES  (TURN_CYCLES),
    .CW           (CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .expire(expire),
    .phase(phase), .accept(accept), .load(load), .load_val(load_val),
    .rd_end(rd_end), .op_end(op_end)
  );

  sram_seq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expire(expire)
  );

  sram_seq_data #(.AW(AW), .DW(DW), .NB(NB)) u_data (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_end(rd_end),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_be(req_be), .bus_in(sram_dq_i),
    .addr_q(sram_addr), .wdata_q(sram_dq_o), .be_q(be_q), .rdata(rdata)
  );

  always_comb ctl = ctl_for(phase);

  assign ctl_idle   = (phase == PH_IDLE);
  assign ack        = accept;
  assign sram_ce1_n = ctl.ce1_n;
  assign sram_ce2   = ctl.ce2;
  assign sram_we_n  = ctl.we_n;
  assign sram_oe_n  = ctl.oe_n;
  assign sram_dq_oe = ctl.dq_oe;

  for (genvar i = 0; i < NB; i++) begin : g_ben
    assign sram_be_n[i] = !(ctl.lanes_on && be_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= op_end;
  end

endmodule

// File: rtl/sram_seq_chk.sv
`timescale 1ns/1ps
module sram_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ack,
  input logic idle,
  input logic done,
  input logic ce1_n,
  input logic ce2,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe
);

  // R6
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));

  // R5
  drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(oe_n));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  strobe_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && oe_n && !ce1_n && ce2));

  // R4
  data_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(dq_oe));

  // R3
  read_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce1_n && ce2));

  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> idle);

endmodule

bind sram_seq_ctrl sram_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .idle(ctl_idle), .done(done),
  .ce1_n(sram_ce1_n), .ce2(sram_ce2), .we_n(sram_we_n), .oe_n(sram_oe_n),
  .dq_oe(sram_dq_oe)
);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;

  localparam int AW = 20, DW = 16;
  localparam int RD_C = 11, WS_C = 1, WL_C = 8, WH_C = 2, TN_C = 4;
  localparam int CLK_NS = 5;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          ack, done;
  logic [DW-1:0] rdata, sram_dq_o, sram_dq_i;
  logic [AW-1:0] sram_addr;
  logic          sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]    sram_be_n;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .READ_CYCLES(RD_C), .WSETUP_CYCLES(WS_C),
    .WE_LOW_CYCLES(WL_C), .WHOLD_CYCLES(WH_C), .TURN_CYCLES(TN_C)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .done(done), .rdata(rdata),
    .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n),
    .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i), .sram_dq_oe(sram_dq_oe));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural RAM, 256 words deep ----------------
  logic [15:0] mem [256];
  int          hold = 0;
  logic        sel, mdrv;
  assign sel  = !sram_ce1_n && sram_ce2 && (sram_be_n != 2'b11);
  assign mdrv = sel && sram_we_n && !sram_oe_n;

  always_comb begin
    if (sram_dq_oe) sram_dq_i = sram_dq_o;
    else begin
      sram_dq_i[7:0]  = (mdrv && !sram_be_n[0]) ? mem[sram_addr[7:0]][7:0]  : 8'h5A;
      sram_dq_i[15:8] = (mdrv && !sram_be_n[1]) ? mem[sram_addr[7:0]][15:8] : 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (sel && !sram_we_n) begin
      if (!sram_be_n[0]) mem[sram_addr[7:0]][7:0]  <= sram_dq_o[7:0];
      if (!sram_be_n[1]) mem[sram_addr[7:0]][15:8] <= sram_dq_o[15:8];
    end
    if (mdrv)          hold <= TN_C;      // keeps driving up to 20 ns after release
    else if (hold > 0) hold <= hold - 1;
  end

  // ---------------- reference model ----------------
  logic [15:0]   ref_mem [256];
  bit            m_busy = 0, m_we = 0, m_done = 0, m_prev_rd = 0;
  int            m_t = 0, m_len = 0, m_turn = 0, len_v, turn_v;
  logic [AW-1:0] m_addr = '0;
  logic [15:0]   m_wdata = '0, m_exp_rd = '0;
  logic [1:0]    m_be = '0;

  function automatic logic [15:0] keep(input logic [1:0] be);
    return {(be[1] ? 8'hFF : 8'h00), (be[0] ? 8'hFF : 8'h00)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_prev_rd <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_t == m_len - 1) begin m_busy <= 0; m_done <= 1; end
        else m_t <= m_t + 1;
      end else if (req) begin
        turn_v = (req_we && m_prev_rd) ? TN_C : 0;
        len_v  = req_we ? (turn_v + WS_C + WL_C + WH_C) : RD_C;
        m_busy <= 1; m_t <= 0; m_we <= req_we; m_addr <= req_addr;
        m_wdata <= req_wdata; m_be <= req_be; m_turn <= turn_v; m_len <= len_v;
        if (req_we) begin
          ref_mem[req_addr[7:0]] <= (ref_mem[req_addr[7:0]] & ~keep(req_be)) |
                                    (req_wdata & keep(req_be));
          m_prev_rd <= 0;
        end else begin
          m_exp_rd  <= ref_mem[req_addr[7:0]] & keep(req_be);
          m_prev_rd <= 1;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  logic [6:0] e_pins, a_pins;
  string      e_tag;
  int         s;

  always @(negedge clk) if (cmp_on) begin
    e_pins = 7'b1011_110;   // ce1_n ce2 we_n oe_n be_n[1:0] dq_oe
    e_tag  = "R1";
    if (m_busy) begin
      if (!m_we) begin
        e_pins = {1'b0, 1'b1, 1'b1, 1'b0, ~m_be, 1'b0};
        e_tag  = "R3";
      end else begin
        s = m_t - m_turn;
        if (s < 0) e_tag = "R5";
        else begin
          e_pins = {1'b0, 1'b1, !(s >= WS_C && s < WS_C + WL_C), 1'b1, ~m_be, 1'b1};
          e_tag  = (m_be == 2'b11) ? "R4" : "R8";
        end
      end
    end
    a_pins = {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe};
    check(a_pins == e_pins, e_tag, "ram pins", a_pins, e_pins);
    check(ack == (req && !m_busy), "R2", "ack", ack, req && !m_busy);
    check(done == m_done, "R7", "done", done, m_done);
    if (m_done && !m_we)
      check(rdata == m_exp_rd, (m_be == 2'b11) ? "R7" : "R8", "rdata", rdata, m_exp_rd);
    if (m_busy) check(sram_addr == m_addr, "R9", "sram_addr", sram_addr, m_addr);
    if (m_busy && m_we && sram_dq_oe)
      check(sram_dq_o == m_wdata, "R9", "sram_dq_o", sram_dq_o, m_wdata);
    check(!(sram_dq_oe && (mdrv || hold > 0)), "R6", "bus fight", sram_dq_oe, 0);
  end

  // ---------------- host tasks ----------------
  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    @(posedge clk); #1;
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    #0;
    while (!ack) begin @(posedge clk); #1; end
    @(posedge clk); #1;
    req = 1'b0; req_we = 1'($urandom); req_addr = AW'($urandom);
    req_wdata = 16'($urandom); req_be = 2'($urandom);
  endtask

  task automatic finish_op();
    while (!done) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, d, be); finish_op();
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] be);
    issue(1'b0, a, 16'h0, be); finish_op();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R7", "watchdog done", 0, 1);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end

    // R10: cycle counts against nanosecond minimums at the bench clock
    check(RD_C * CLK_NS >= 55, "R10", "read cycle ns", RD_C * CLK_NS, 55);
    check(WL_C * CLK_NS >= 40, "R10", "write pulse ns", WL_C * CLK_NS, 40);
    check((WS_C + WL_C + WH_C) * CLK_NS >= 55, "R10", "write cycle ns",
          (WS_C + WL_C + WH_C) * CLK_NS, 55);
    check((WS_C + WL_C) * CLK_NS >= 25, "R10", "data setup ns", (WS_C + WL_C) * CLK_NS, 25);
    check(TN_C * CLK_NS >= 20, "R10", "bus release ns", TN_C * CLK_NS, 20);

    // R1: levels while in reset
    repeat (3) @(negedge clk);
    check({sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe} == 7'b1011_110,
          "R1", "reset pins", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe},
          7'b1011_110);
    check(done == 1'b0, "R1", "reset done", done, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    wr(20'h00010, 16'h1234, 2'b11);      // first write, no turnaround
    rd(20'h00010, 2'b11);
    wr(20'h00011, 16'hABCD, 2'b01);      // write after read, lower lane only (R5, R8)
    rd(20'h00011, 2'b11);
    rd(20'h00011, 2'b10);
    wr(20'h00011, 16'h7700, 2'b10);      // upper lane only
    rd(20'h00011, 2'b01);
    rd(20'h00011, 2'b10);
    rd(20'h00011, 2'b11);
    wr(20'h00010, 16'hFFFF, 2'b00);      // R8: no lane, no change
    rd(20'h00010, 2'b11);
    rd(20'h00010, 2'b00);
    wr(20'hFFFFF, 16'hC3C3, 2'b11);      // top of address range
    rd(20'hFFFFF, 2'b11);
    wr(20'h000FE, 16'h0101, 2'b11);      // write after write, no turnaround
    wr(20'h000FE, 16'h2200, 2'b10);
    rd(20'h000FE, 2'b11);

    // back-to-back random traffic with scrambled host fields between requests
    for (int i = 0; i < 80; i++) begin
      issue(1'($urandom), {12'($urandom), 8'h40 + 8'($urandom % 16)},
            16'($urandom), 2'($urandom));
    end
    repeat (40) @(posedge clk);
    #1;
    check(done == 1'b0 && sram_ce1_n == 1'b1, "R1", "idle after traffic",
          {done, sram_ce1_n}, 2'b01);

    summary();
    $finish;
  end

endmodule